// File: doc/BRIEF.md
# Vector Loop Issue Sequencer

This control block sits between instruction fetch and the execute units of a scalar core that also runs vector-prefixed instructions. It accepts one fetched instruction at a time. A vector instruction is then issued to execute once per element, from the current step up to the vector length. The step advances on each accepted sub-instruction, and fetch is not re-engaged until the loop is over. The step counter and the vector length make up the vector state. Both are held, read and updated here, so each iteration sees the step that the previous one produced.

Control returns to fetch in four cases. The first is when the last element has been accepted; the program counter then advances by the instruction length, 4 bytes plain or 8 bytes prefixed. The second is a stop request, which leaves the step where it is so that the loop can be resumed. The third and fourth are when the trap or branch side writes a new program counter or a new vector state. A redirect always beats the sequencer's own updates: the sequential next address and the step increment are both discarded. Only the set-length instruction, which is never looped, changes the vector length from the instruction stream.

Top module: `vloop_seq`

## Requirements
- R1: After reset the sequencer waits for fetch. fetch_ready_o is 1, exe_valid_o is 0, the program counter equals RESET_PC, and both step and vector length are 0.
- R2: A fetch handshake (fetch_valid_i and fetch_ready_o both high) of a scalar, a set-length instruction or a vector instruction with non-zero length moves to issue. In the next cycle exe_valid_o is 1 and fetch_ready_o is 0.
- R3: A vector instruction presents its current step on exe_step_o. The step increments by one only on a cycle where exe_valid_o and exe_ready_i are both 1, and fetch_ready_o stays 0 between sub-instructions.
- R4: The loop ends on the handshake whose step plus one is greater than or equal to the vector length. The step then becomes 0, the program counter advances by 8 if fetch_prefixed_i was 1 at fetch and by 4 otherwise, and the block returns to fetch.
- R5: A scalar instruction (fetch_vector_i=0, fetch_setvl_i=0) is issued once. On its handshake the program counter advances by the instruction length, and the step and length are unchanged.
- R6: A vector instruction fetched while the length is 0 issues nothing. The program counter advances by its length in the fetch cycle, and the block stays ready for fetch.
- R7: While stop_i is 1, exe_valid_o and fetch_ready_o are 0. A stop during issue returns the block to fetch with step and program counter unchanged, so re-fetching the instruction resumes at that step.
- R8: pc_wr_i loads pc_wr_data_i into the program counter in the next cycle. It overrides any sequential advance, holds fetch_ready_o at 0 in that cycle, and during issue returns the block to fetch with the step unchanged.
- R9: vs_wr_i loads vs_wr_step_i and vs_wr_vl_i into the step and the length in the next cycle. It overrides the step update and the program-counter advance, holds fetch_ready_o at 0, and during issue returns the block to fetch.
- R10: A set-length instruction (fetch_setvl_i=1) is issued once whatever the current length. On its handshake the length becomes fetch_newvl_i as sampled at fetch, the step becomes 0 and the program counter advances.
- R11: When a redirect (pc_wr_i or vs_wr_i) and an issue handshake coincide, the redirect wins. There is no step increment, no sequential advance and no further issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Stop request; blocks any new issue or fetch |
| fetch_valid_i | input | 1 | A fetched instruction is offered |
| fetch_ready_o | output | 1 | Sequencer accepts a fetched instruction |
| fetch_vector_i | input | 1 | Offered instruction is vector-prefixed and loops |
| fetch_prefixed_i | input | 1 | Offered instruction is 8 bytes long |
| fetch_setvl_i | input | 1 | Offered instruction sets the vector length |
| fetch_newvl_i | input | VL_W | New vector length carried by a set-length instruction |
| exe_valid_o | output | 1 | A sub-instruction is offered to execute |
| exe_ready_i | input | 1 | Execute accepts the sub-instruction |
| exe_pc_o | output | PC_W | Program counter of the instruction being issued |
| exe_step_o | output | VL_W | Current step (element index) |
| vl_o | output | VL_W | Current vector length |
| pc_wr_i | input | 1 | Trap or branch writes the program counter |
| pc_wr_data_i | input | PC_W | New program counter |
| vs_wr_i | input | 1 | Trap unit writes the vector state |
| vs_wr_step_i | input | VL_W | New step |
| vs_wr_vl_i | input | VL_W | New vector length |

## Verification
The assertions check four things on every cycle. Writes from the trap or branch side land the following cycle. The step and the program counter hold whenever no handshake, skip or write touches them. Each mid-loop handshake adds exactly one to the step, and a stop during issue always leads back to fetch. Other behaviour can only be shown by the bench's scenarios, because it depends on sequences of inputs. Those scenarios cover the number of sub-instructions a loop issues, the 4- versus 8-byte advance, the zero-length skip, and resuming at the saved step after a stop. They also cover the outcome when a redirect meets the final handshake, where the program counter must keep the written value rather than the sequential one.

// File: rtl/vloop_pkg.sv
package vloop_pkg;

  typedef enum logic {
    SEQ_FETCH = 1'b0,
    SEQ_ISSUE = 1'b1
  } seq_state_e;

  // Byte length of an instruction: prefixed forms occupy two words.
  function automatic logic [3:0] insn_bytes(input logic prefixed);
    return prefixed ? 4'd8 : 4'd4;
  endfunction

endpackage

// File: rtl/vloop_pc_reg.sv
module vloop_pc_reg #(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [PC_W-1:0] wr_data_i,
  input  logic            adv_i,
  input  logic            len8_i,
  output logic [PC_W-1:0] pc_o
);
  import vloop_pkg::*;

  logic [PC_W-1:0] pc_q;

  function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] pc,
                                             input logic len8);
    return pc + PC_W'(insn_bytes(len8));
  endfunction

  // An external write always wins over the sequential next address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= RESET_PC;
    else if (wr_i)   pc_q <= wr_data_i;
    else if (adv_i)  pc_q <= seq_pc(pc_q, len8_i);
  end

  assign pc_o = pc_q;

  p_pc_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> pc_q == $past(wr_data_i));

  p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !adv_i) |=> $stable(pc_q));

endmodule

// File: rtl/vloop_vstate_reg.sv
module vloop_vstate_reg #(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [VL_W-1:0] wr_step_i,
  input  logic [VL_W-1:0] wr_vl_i,
  input  logic            step_inc_i,
  input  logic            step_clr_i,
  input  logic            vl_load_i,
  input  logic [VL_W-1:0] vl_load_val_i,
  output logic [VL_W-1:0] step_o,
  output logic [VL_W-1:0] vl_o,
  output logic            last_o
);

  logic [VL_W-1:0] step_q;
  logic [VL_W-1:0] vl_q;

  // Last element when step+1 reaches or passes the length (widened to avoid wrap).
  function automatic logic is_last(input logic [VL_W-1:0] step,
                                   input logic [VL_W-1:0] vl);
    return ({1'b0, step} + (VL_W+1)'(1)) >= {1'b0, vl};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      vl_q   <= '0;
    end else if (wr_i) begin
      step_q <= wr_step_i;
      vl_q   <= wr_vl_i;
    end else begin
      if (vl_load_i)       vl_q   <= vl_load_val_i;
      if (step_clr_i)      step_q <= '0;
      else if (step_inc_i) step_q <= step_q + VL_W'(1);
    end
  end

  assign step_o = step_q;
  assign vl_o   = vl_q;
  assign last_o = is_last(step_q, vl_q);

  p_vs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (step_q == $past(wr_step_i) && vl_q == $past(wr_vl_i)));

  p_step_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !step_inc_i && !step_clr_i) |=> $stable(step_q));

  p_vl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !vl_load_i) |=> $stable(vl_q));

endmodule

// File: rtl/vloop_seq.sv
module vloop_seq #(
  parameter int              PC_W     = 32,
  parameter int              VL_W     = 7,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop_i,
  input  logic            fetch_valid_i,
  output logic            fetch_ready_o,
  input  logic            fetch_vector_i,
  input  logic            fetch_prefixed_i,
  input  logic            fetch_setvl_i,
  input  logic [VL_W-1:0] fetch_newvl_i,
  output logic            exe_valid_o,
  input  logic            exe_ready_i,
  output logic [PC_W-1:0] exe_pc_o,
  output logic [VL_W-1:0] exe_step_o,
  output logic [VL_W-1:0] vl_o,
  input  logic            pc_wr_i,
  input  logic [PC_W-1:0] pc_wr_data_i,
  input  logic            vs_wr_i,
  input  logic [VL_W-1:0] vs_wr_step_i,
  input  logic [VL_W-1:0] vs_wr_vl_i
);
  import vloop_pkg::*;

  seq_state_e      st_q, st_d;
  logic            cur_vec_q, cur_pfx_q, cur_setvl_q;
  logic [VL_W-1:0] cur_newvl_q;

  // Named internal events, used by the logic and by the assertions.
  logic redirect, accept, skip, fire, last, done;
  logic step_inc, step_clr, vl_load, pc_adv, len8;
  logic [VL_W-1:0] step, vl;

  assign redirect      = pc_wr_i | vs_wr_i;
  assign fetch_ready_o = (st_q == SEQ_FETCH) && !stop_i && !redirect;
  assign accept        = fetch_valid_i && fetch_ready_o;
  assign skip          = accept && fetch_vector_i && !fetch_setvl_i && (vl == '0);

  assign exe_valid_o = (st_q == SEQ_ISSUE) && !stop_i;
  assign fire        = exe_valid_o && exe_ready_i;
  assign done        = fire && !redirect && (!cur_vec_q || last);
  assign step_inc    = fire && !redirect && cur_vec_q && !last;
  assign vl_load     = fire && !redirect && cur_setvl_q;
  assign step_clr    = done && (cur_vec_q || cur_setvl_q);
  assign pc_adv      = done || skip;
  assign len8        = (st_q == SEQ_FETCH) ? fetch_prefixed_i : cur_pfx_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_FETCH: if (accept && !skip)              st_d = SEQ_ISSUE;
      SEQ_ISSUE: if (redirect || stop_i || done)   st_d = SEQ_FETCH;
      default:                                     st_d = SEQ_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SEQ_FETCH;
      cur_vec_q   <= 1'b0;
      cur_pfx_q   <= 1'b0;
      cur_setvl_q <= 1'b0;
      cur_newvl_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        cur_vec_q   <= fetch_vector_i && !fetch_setvl_i;
        cur_pfx_q   <= fetch_prefixed_i;
        cur_setvl_q <= fetch_setvl_i;
        cur_newvl_q <= fetch_newvl_i;
      end
    end
  end

  vloop_pc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (pc_wr_i),
    .wr_data_i (pc_wr_data_i),
    .adv_i     (pc_adv),
    .len8_i    (len8),
    .pc_o      (exe_pc_o)
  );

  vloop_vstate_reg #(.VL_W(VL_W)) u_vs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_i          (vs_wr_i),
    .wr_step_i     (vs_wr_step_i),
    .wr_vl_i       (vs_wr_vl_i),
    .step_inc_i    (step_inc),
    .step_clr_i    (step_clr),
    .vl_load_i     (vl_load),
    .vl_load_val_i (cur_newvl_q),
    .step_o        (step),
    .vl_o          (vl),
    .last_o        (last)
  );

  assign exe_step_o = step;
  assign vl_o       = vl;

  p_step_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_inc |=> exe_step_o == VL_W'($past(exe_step_o) + VL_W'(1)));

  p_loop_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cur_vec_q) |=> (exe_step_o == '0 && st_q == SEQ_FETCH));

  p_skip_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> st_q == SEQ_FETCH);

  p_stop_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_ISSUE && stop_i) |=> (st_q == SEQ_FETCH && $stable(exe_step_o)));

  p_redirect_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && redirect) |=> st_q == SEQ_FETCH);

endmodule

// File: tb/vloop_seq_tb.sv
module vloop_seq_tb;
  localparam int PC_W = 32;
  localparam int VL_W = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            stop_i = 1'b0;
  logic            fetch_valid_i = 1'b0;
  logic            fetch_ready_o;
  logic            fetch_vector_i = 1'b0;
  logic            fetch_prefixed_i = 1'b0;
  logic            fetch_setvl_i = 1'b0;
  logic [VL_W-1:0] fetch_newvl_i = '0;
  logic            exe_valid_o;
  logic            exe_ready_i = 1'b0;
  logic [PC_W-1:0] exe_pc_o;
  logic [VL_W-1:0] exe_step_o;
  logic [VL_W-1:0] vl_o;
  logic            pc_wr_i = 1'b0;
  logic [PC_W-1:0] pc_wr_data_i = '0;
  logic            vs_wr_i = 1'b0;
  logic [VL_W-1:0] vs_wr_step_i = '0;
  logic [VL_W-1:0] vs_wr_vl_i = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  vloop_seq #(.PC_W(PC_W), .VL_W(VL_W), .RESET_PC('0)) u_dut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
    #2;
  endtask

  // Offer one instruction; returns just after the accepting edge.
  task automatic fetch_one(input logic vec, input logic pfx, input logic setvl,
                           input logic [VL_W-1:0] nvl);
    fetch_vector_i = vec; fetch_prefixed_i = pfx;
    fetch_setvl_i = setvl; fetch_newvl_i = nvl;
    fetch_valid_i = 1'b1;
    #1 chk("R2", "fetch_ready before accept", int'(fetch_ready_o), 1);
    nxt();
    fetch_valid_i = 1'b0;
    #1;
  endtask

  task automatic write_vs(input logic [VL_W-1:0] s, input logic [VL_W-1:0] l);
    vs_wr_step_i = s; vs_wr_vl_i = l; vs_wr_i = 1'b1;
    #1 chk("R9", "fetch_ready during write", int'(fetch_ready_o), 0);
    nxt();
    vs_wr_i = 1'b0;
    #1 chk("R9", "step after write", int'(exe_step_o), int'(s));
    chk("R9", "vl after write", int'(vl_o), int'(l));
  endtask

  task automatic t_reset();
    chk("R1", "fetch_ready", int'(fetch_ready_o), 1);
    chk("R1", "exe_valid", int'(exe_valid_o), 0);
    chk("R1", "pc", int'(exe_pc_o), 0);
    chk("R1", "step", int'(exe_step_o), 0);
    chk("R1", "vl", int'(vl_o), 0);
  endtask

  task automatic t_setvl();
    exe_ready_i = 1'b0;
    fetch_one(1'b0, 1'b0, 1'b1, 7'd4);
    chk("R2", "exe_valid after accept", int'(exe_valid_o), 1);
    chk("R2", "fetch_ready after accept", int'(fetch_ready_o), 0);
    exe_ready_i = 1'b1;
    nxt();
    chk("R10", "vl loaded", int'(vl_o), 4);
    chk("R10", "step cleared", int'(exe_step_o), 0);
    chk("R10", "pc advanced", int'(exe_pc_o), 4);
    chk("R10", "issued once", int'(exe_valid_o), 0);
  endtask

  task automatic t_vector_loop();
    exe_ready_i = 1'b0;
    fetch_one(1'b1, 1'b1, 1'b0, '0);
    chk("R3", "step at start", int'(exe_step_o), 0);
    nxt();
    chk("R3", "no advance without ready", int'(exe_step_o), 0);
    exe_ready_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1 chk("R3", "step sequence", int'(exe_step_o), i);
      chk("R3", "fetch idle in loop", int'(fetch_ready_o), 0);
      chk("R3", "issuing", int'(exe_valid_o), 1);
      nxt();
    end
    chk("R4", "step wrapped", int'(exe_step_o), 0);
    chk("R4", "pc plus 8", int'(exe_pc_o), 12);
    chk("R4", "back to fetch", int'(fetch_ready_o), 1);
  endtask

  task automatic t_scalar();
    exe_ready_i = 1'b1;
    fetch_one(1'b0, 1'b0, 1'b0, '0);
    chk("R5", "issued", int'(exe_valid_o), 1);
    nxt();
    chk("R5", "pc plus 4", int'(exe_pc_o), 16);
    chk("R5", "vl unchanged", int'(vl_o), 4);
    chk("R5", "done", int'(exe_valid_o), 0);
  endtask

  task automatic t_zero_vl();
    write_vs('0, '0);
    fetch_one(1'b1, 1'b1, 1'b0, '0);
    chk("R6", "no issue", int'(exe_valid_o), 0);
    chk("R6", "pc plus 8", int'(exe_pc_o), 24);
    chk("R6", "still fetching", int'(fetch_ready_o), 1);
  endtask

  task automatic t_stop();
    write_vs('0, 7'd3);
    exe_ready_i = 1'b1;
    fetch_one(1'b1, 1'b0, 1'b0, '0);
    nxt();
    chk("R7", "one element done", int'(exe_step_o), 1);
    stop_i = 1'b1;
    #1 chk("R7", "valid masked", int'(exe_valid_o), 0);
    nxt();
    chk("R7", "step kept", int'(exe_step_o), 1);
    chk("R7", "pc kept", int'(exe_pc_o), 24);
    chk("R7", "fetch masked", int'(fetch_ready_o), 0);
    stop_i = 1'b0;
    #1 chk("R7", "returned to fetch", int'(fetch_ready_o), 1);
    chk("R7", "not issuing", int'(exe_valid_o), 0);
    fetch_one(1'b1, 1'b0, 1'b0, '0);
    chk("R7", "resumed step", int'(exe_step_o), 1);
    nxt();
    chk("R7", "next step", int'(exe_step_o), 2);
    nxt();
    chk("R7", "loop closed pc", int'(exe_pc_o), 28);
    chk("R7", "loop closed step", int'(exe_step_o), 0);
  endtask

  task automatic t_pc_redirect();
    exe_ready_i = 1'b0;
    fetch_one(1'b1, 1'b0, 1'b0, '0);
    exe_ready_i = 1'b1;
    nxt();
    chk("R3", "first fire", int'(exe_step_o), 1);
    pc_wr_data_i = 32'h200; pc_wr_i = 1'b1;
    nxt();
    pc_wr_i = 1'b0;
    #1 chk("R8", "pc written", int'(exe_pc_o), 32'h200);
    chk("R11", "step not advanced", int'(exe_step_o), 1);
    chk("R8", "back to fetch", int'(fetch_ready_o), 1);
    chk("R11", "no further issue", int'(exe_valid_o), 0);
  endtask

  task automatic t_vs_redirect_last();
    write_vs(7'd2, 7'd3);
    exe_ready_i = 1'b1;
    fetch_one(1'b1, 1'b0, 1'b0, '0);
    chk("R11", "at last element", int'(exe_step_o), 2);
    vs_wr_step_i = '0; vs_wr_vl_i = 7'd5; vs_wr_i = 1'b1;
    nxt();
    vs_wr_i = 1'b0;
    #1 chk("R11", "pc not advanced", int'(exe_pc_o), 32'h200);
    chk("R9", "vl from write", int'(vl_o), 5);
    chk("R9", "step from write", int'(exe_step_o), 0);
    chk("R9", "back to fetch", int'(fetch_ready_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    t_reset();
    t_setvl();
    t_vector_loop();
    t_scalar();
    t_zero_vl();
    t_stop();
    t_pc_redirect();
    t_vs_redirect_last();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule